// File: doc/BRIEF.md
# Memory-to-Memory Three-Address Instruction Sequencer

The block is a small multicycle core. Every instruction names two source locations and one destination location in memory. All of its memory traffic passes through one address register and one data register on a single synchronous memory port. The core reads the four instruction words at the program counter. It then decodes the opcode and reads each source operand at its effective address. The arithmetic unit combines the two operands into a result register, and the result is written back to the destination location. After that the core fetches the next instruction.

A system connects the port to a word-wide memory that returns read data one cycle after the read strobe. It places a program at address 0 and releases reset. The core runs until it reaches a halt opcode. It then raises `done` and issues no further memory access.

Top module: `mm3_seq`

## Requirements
- R1: During reset and on the first cycle after it, `done` is low, `mem_wr` is low, `mem_rd` is high and `mem_addr` is 0.
- R2: An instruction is four consecutive words: opcode, source A address, source B address and destination address. These four words are read in that order at PC, PC+1, PC+2 and PC+3.
- R3: A read asserts `mem_rd` for exactly one cycle, with the address on `mem_addr`. The data is expected on `mem_rdata` one cycle later, and `mem_rd` is never high on two consecutive cycles.
- R4: After decode, source A is read at the address given in word 1, and source B is then read at the address given in word 2. Each uses its own read cycle.
- R5: Opcode 1 stores A+B, opcode 2 stores A-B and opcode 3 stores the low 16 bits of A*B. All arithmetic wraps modulo 2^16.
- R6: Each arithmetic instruction performs exactly one write. `mem_wr` is high for one cycle, `mem_addr` holds the destination address and `mem_wdata` holds the result.
- R7: The PC advances by 4 after each fetch, so successive instructions come from consecutive 4-word slots. A later instruction sees results that earlier ones stored.
- R8: Opcode 0, and any opcode above 3, halts the core. `done` rises and stays high until reset. No read or write follows, and the halt's destination word is left unchanged.
- R9: `mem_rd` and `mem_wr` are never high in the same cycle.
- R10: An arithmetic instruction takes 22 cycles. `done` is seen 13 cycles after the fetch of a halt instruction begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | AW | Address register driving the memory |
| mem_rd | output | 1 | Read strobe, data due on the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | DW | Data register driving the write data |
| mem_rdata | input | DW | Read data, one cycle after `mem_rd` |
| done | output | 1 | High once a halt has been decoded |

## Verification
Each memory word takes three cycles: strobe, data wait and capture. An arithmetic instruction therefore produces its single write on its 22nd cycle, and `done` appears on the 13th cycle of a halt. The bench counts cycles from reset release and compares the count at `done` with 22 times the instruction count plus 13. All sampling happens a short time after the falling edge, when every registered output has settled. The bench logs every read address and checks the order against the instruction layout. Stored results are read back from the memory model only once `done` is high. It then waits 20 further cycles and confirms that neither access counter has moved.

// File: rtl/mm3_seq.sv
module mm3_seq #(
  parameter int DW = 16,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          done
);

  localparam logic [DW-1:0] OP_ADD = DW'(1);
  localparam logic [DW-1:0] OP_SUB = DW'(2);
  localparam logic [DW-1:0] OP_MUL = DW'(3);

  typedef enum logic [2:0] {
    S_RD, S_WAIT, S_LATCH, S_DEC, S_EXE, S_WSET, S_WR, S_HALT
  } st_t;

  st_t st;
  logic [2:0]    ph;
  logic [AW-1:0] pc, mar, a_ea, b_ea, d_ea;
  logic [DW-1:0] mdr, ir, opa, opb, acc, alu;
  logic          op_ok;

  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign mem_rd    = (st == S_RD);
  assign mem_wr    = (st == S_WR);
  assign done      = (st == S_HALT);

  assign op_ok = (ir == OP_ADD) || (ir == OP_SUB) || (ir == OP_MUL);

  always_comb begin
    case (ir)
      OP_ADD:  alu = opa + opb;
      OP_SUB:  alu = opa - opb;
      OP_MUL:  alu = opa * opb;
      default: alu = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_RD;
      ph   <= '0;
      pc   <= '0;
      mar  <= '0;
      mdr  <= '0;
      ir   <= '0;
      a_ea <= '0;
      b_ea <= '0;
      d_ea <= '0;
      opa  <= '0;
      opb  <= '0;
      acc  <= '0;
    end else begin
      case (st)
        S_RD:   st <= S_WAIT;
        S_WAIT: begin
          mdr <= mem_rdata;
          st  <= S_LATCH;
        end
        S_LATCH: begin
          case (ph)
            3'd0: begin ir   <= mdr;           mar <= pc + AW'(1); ph <= 3'd1; st <= S_RD; end
            3'd1: begin a_ea <= mdr[AW-1:0];   mar <= pc + AW'(2); ph <= 3'd2; st <= S_RD; end
            3'd2: begin b_ea <= mdr[AW-1:0];   mar <= pc + AW'(3); ph <= 3'd3; st <= S_RD; end
            3'd3: begin d_ea <= mdr[AW-1:0];   pc  <= pc + AW'(4); st <= S_DEC; end
            3'd4: begin opa  <= mdr;           mar <= b_ea;        ph <= 3'd5; st <= S_RD; end
            default: begin opb <= mdr; st <= S_EXE; end
          endcase
        end
        S_DEC: begin
          if (op_ok) begin
            mar <= a_ea;
            ph  <= 3'd4;
            st  <= S_RD;
          end else begin
            st <= S_HALT;
          end
        end
        S_EXE: begin
          acc <= alu;
          st  <= S_WSET;
        end
        S_WSET: begin
          mar <= d_ea;
          mdr <= acc;
          st  <= S_WR;
        end
        S_WR: begin
          mar <= pc;
          ph  <= 3'd0;
          st  <= S_RD;
        end
        default: st <= S_HALT;
      endcase
    end
  end

endmodule

// File: rtl/mm3_seq_chk.sv
module mm3_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic mem_rd,
  input logic mem_wr,
  input logic done
);

  // R9
  no_rdwr_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R3
  rd_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  // R6
  wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_rd && !mem_wr));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

endmodule

bind mm3_seq mm3_seq_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .mem_rd (mem_rd),
  .mem_wr (mem_wr),
  .done   (done)
);

// File: tb/sim_mm3_seq.sv
`timescale 1ns/1ps
module sim_mm3_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr, done;

  logic        ld_en = 1'b0;
  logic [9:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic [15:0] mem [0:1023];

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  mm3_seq u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done)
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
  end

  logic [15:0] rlog [0:1023];
  int rcnt, wcnt;
  always @(negedge clk) begin
    if (!rst_n) begin
      rcnt <= 0;
      wcnt <= 0;
    end else begin
      if (mem_rd) begin
        if (rcnt < 1024) rlog[rcnt] <= mem_addr;
        rcnt <= rcnt + 1;
      end
      if (mem_wr) wcnt <= wcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic poke(input int a, input int d);
    ld_addr = a[9:0];
    ld_data = d[15:0];
    ld_en = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [15:0] expv(input int op, input logic [15:0] a, input logic [15:0] b);
    case (op)
      1: return a + b;
      2: return a - b;
      default: return a * b;
    endcase
  endfunction

  task automatic release_and_check_reset();
    ld_en = 1'b0;
    @(negedge clk);
    chk(!done && !mem_wr, "R1 reset outputs", {done, mem_wr}, 0);
    rst_n = 1'b1;
    #1;
    chk(mem_rd && mem_addr == 16'd0 && !done && !mem_wr, "R1 first access",
        mem_addr, 0);
  endtask

  task automatic run_to_done(input int exp_cyc, input string tag);
    int cyc = 0;
    while (!done && cyc < 6000) begin
      @(negedge clk);
      #1;
      cyc++;
    end
    chk(done, {tag, " watchdog"}, done, 1);
    chk(cyc == exp_cyc, {"R10 cycles ", tag}, cyc, exp_cyc);
  endtask

  task automatic check_quiet(input string tag);
    int r0 = rcnt;
    int w0 = wcnt;
    repeat (20) @(negedge clk);
    #1;
    chk(done && rcnt == r0 && wcnt == w0, {"R8 quiet after halt ", tag},
        rcnt - r0 + wcnt - w0, 0);
  endtask

  logic [15:0] vals [0:5];

  initial begin
    vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h0002;
    vals[3] = 16'h7FFF; vals[4] = 16'h8000; vals[5] = 16'hFFFF;

    // Run 1: sweep of all opcodes over all operand pairs
    repeat (2) @(negedge clk);
    for (int i = 0; i < 6; i++) poke(12'h300 + i, vals[i]);
    for (int k = 0; k < 108; k++) begin
      int op = k / 36 + 1;
      int i = (k % 36) / 6;
      int j = k % 6;
      poke(4*k, op);
      poke(4*k + 1, 12'h300 + i);
      poke(4*k + 2, 12'h300 + j);
      poke(4*k + 3, 12'h380 + k);
      poke(12'h380 + k, 16'hA5A5);
    end
    poke(432, 0); poke(433, 12'h300); poke(434, 12'h301); poke(435, 12'h3F0);
    poke(12'h3F0, 16'hBEEF);
    release_and_check_reset();
    run_to_done(108*22 + 13, "sweep");
    for (int k = 0; k < 108; k++) begin
      int op = k / 36 + 1;
      int i = (k % 36) / 6;
      int j = k % 6;
      logic [15:0] e = expv(op, vals[i], vals[j]);
      chk(mem[12'h380 + k] == e, "R5 result", mem[12'h380 + k], e);
    end
    begin
      bit fo = 1'b1;
      bit oo = 1'b1;
      for (int k = 0; k < 108; k++) begin
        int i = (k % 36) / 6;
        int j = k % 6;
        for (int w = 0; w < 4; w++)
          if (rlog[6*k + w] != 16'(4*k + w)) fo = 1'b0;
        if (rlog[6*k + 4] != 16'(12'h300 + i)) oo = 1'b0;
        if (rlog[6*k + 5] != 16'(12'h300 + j)) oo = 1'b0;
      end
      for (int w = 0; w < 4; w++)
        if (rlog[648 + w] != 16'(432 + w)) fo = 1'b0;
      chk(fo, "R2 R7 fetch order", fo, 1);
      chk(oo, "R4 operand order", oo, 1);
    end
    chk(rcnt == 652, "R3 read count", rcnt, 652);
    chk(wcnt == 108, "R6 write count", wcnt, 108);
    chk(mem[12'h3F0] == 16'hBEEF, "R8 halt dest untouched", mem[12'h3F0], 16'hBEEF);
    check_quiet("sweep");

    // Run 2: chained results and an unknown opcode as halt
    rst_n = 1'b0;
    @(negedge clk);
    poke(12'h300, 5); poke(12'h301, 7); poke(12'h302, 0); poke(12'h303, 0);
    poke(12'h304, 16'h1234);
    poke(0, 3); poke(1, 12'h300); poke(2, 12'h301); poke(3, 12'h302);
    poke(4, 2); poke(5, 12'h302); poke(6, 12'h300); poke(7, 12'h303);
    poke(8, 1); poke(9, 12'h303); poke(10, 12'h303); poke(11, 12'h303);
    poke(12, 9); poke(13, 12'h300); poke(14, 12'h300); poke(15, 12'h304);
    release_and_check_reset();
    run_to_done(3*22 + 13, "chain");
    chk(mem[12'h302] == 16'd35, "R7 chained mul", mem[12'h302], 35);
    chk(mem[12'h303] == 16'd60, "R7 chained sub then add", mem[12'h303], 60);
    chk(mem[12'h304] == 16'h1234, "R8 unknown opcode no write", mem[12'h304], 16'h1234);
    chk(wcnt == 3, "R6 chain write count", wcnt, 3);
    chk(rcnt == 22, "R3 chain read count", rcnt, 22);
    check_quiet("chain");

    // Run 3: halt as the very first instruction
    rst_n = 1'b0;
    @(negedge clk);
    poke(0, 0); poke(1, 12'h300); poke(2, 12'h300); poke(3, 12'h300);
    poke(12'h300, 16'h0042);
    release_and_check_reset();
    run_to_done(13, "halt0");
    chk(wcnt == 0 && mem[12'h300] == 16'h0042, "R8 immediate halt", wcnt, 0);
    chk(rlog[0] == 0 && rlog[3] == 3 && rcnt == 4, "R2 halt fetch", rcnt, 4);
    check_quiet("halt0");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule